// File: doc/BRIEF.md
# Two-Level Segmented Page Translator

This block converts a 32-bit logical address into a 24-bit physical address by walking two tables held in ordinary memory. The top four bits of the logical address pick one of sixteen segment descriptors. Each descriptor gives the base of a page table and the number of entries that table holds. The next sixteen bits index that page table once the index has passed a range check against the descriptor length. The page table entry supplies a 12-bit frame number, which is joined to the untouched 12-bit byte offset.

Both table reads share one memory read port with a request pulse and a later response strobe, so the walk always takes two reads in strict order. The descriptor read comes first and the entry read follows only after its response. A translation ends with either a one-cycle done pulse carrying the physical address, or a one-cycle fault pulse carrying a reason code. A segment whose descriptor length is zero is treated as unused. The descriptor table base is an input held steady by the surrounding logic.

Top module: `segpage_xlate`

## Requirements
- R1: After synchronous reset, busy, done, fault and mem_rd_en are all low.
- R2: The logical address is split as segment number in bits [31:28], page index within the segment in bits [27:12], and byte offset in bits [11:0].
- R3: The descriptor is read at word address seg_tbl_base plus the segment number, with 16-bit wrap. The descriptor word holds the page table base in bits [15:0] and the length in entries in bits [31:16].
- R4: Reads are strictly sequential. Each read is a one-cycle mem_rd_en pulse. The entry read is issued only after the descriptor response arrives, and a successful walk makes exactly two reads.
- R5: The entry is read at descriptor base plus page index, with 16-bit wrap. Entry bit 15 is the valid flag and bits [11:0] are the frame number. On success paddr equals {frame, offset} and done pulses for one cycle.
- R6: A page index greater than or equal to the descriptor length gives fault with fault_code 1 and issues no entry read. An index of length minus one translates, and an index equal to the length faults.
- R7: A descriptor with length zero makes every access to that segment fault with code 1.
- R8: An entry with bit 15 clear gives fault with fault_code 2 and no done pulse.
- R9: busy is high from the cycle after a request is accepted until the done or fault cycle. A req_valid seen while busy is ignored and starts no reads.
- R10: done and fault are never high together. Each is a single-cycle pulse, after which the block is idle and accepts a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation; accepted only while idle |
| req_laddr | input | 32 | Logical address to translate |
| seg_tbl_base | input | 16 | Word address of the segment descriptor table |
| mem_rd_en | output | 1 | One-cycle read request to table memory |
| mem_rd_addr | output | 16 | Word address of the read |
| mem_rd_valid | input | 1 | Read response strobe |
| mem_rd_data | input | 32 | Read response word |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Translation succeeded this cycle |
| paddr | output | 24 | Physical address, valid with done |
| fault | output | 1 | Translation failed this cycle |
| fault_code | output | 2 | 1 = index out of range, 2 = entry not valid |

## Verification
The bench goes after the range boundary. An index equal to the length must fault and one less must translate, so an off-by-one compare would either accept a page past the table or reject the last real page. A zero-length segment must trap, while a design that skipped the check would read a stray entry and may return a frame from outside the table. An entry with the valid bit clear must fault with code 2, so a design that ignored the flag would report done with garbage. The bench also counts reads to catch an entry read issued after a range fault and a second walk started by a request that arrived while busy.

// File: rtl/segpage_pkg.sv
package segpage_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG,
    ST_PTE,
    ST_DONE,
    ST_FAULT
  } walk_state_t;

  localparam logic [1:0] FLT_NONE    = 2'd0;
  localparam logic [1:0] FLT_RANGE   = 2'd1;
  localparam logic [1:0] FLT_INVALID = 2'd2;

  // descriptor and entry field positions inside a memory word
  localparam int SEG_BASE_LSB  = 0;
  localparam int SEG_LEN_LSB   = 16;
  localparam int PTE_FRAME_LSB = 0;
  localparam int PTE_VALID_BIT = 15;

endpackage

// File: rtl/segpage_split.sv
module segpage_split #(
  parameter int LAW  = 32,
  parameter int SEGW = 4,
  parameter int OFFW = 12,
  localparam int IDXW = LAW - SEGW - OFFW
) (
  input  logic [LAW-1:0]  laddr,
  output logic [SEGW-1:0] seg,
  output logic [IDXW-1:0] idx,
  output logic [OFFW-1:0] off
);

  always_comb begin
    seg = laddr[LAW-1 -: SEGW];
    idx = laddr[OFFW +: IDXW];
    off = laddr[OFFW-1:0];
  end

endmodule

// File: rtl/segpage_entry_decode.sv
module segpage_entry_decode
  import segpage_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 16,
  parameter int LENW = 16,
  parameter int FRW  = 12
) (
  input  logic [DW-1:0]   word,
  output logic [AW-1:0]   seg_base,
  output logic [LENW-1:0] seg_len,
  output logic            pte_valid,
  output logic [FRW-1:0]  pte_frame
);

  always_comb begin
    seg_base  = word[SEG_BASE_LSB +: AW];
    seg_len   = word[SEG_LEN_LSB +: LENW];
    pte_valid = word[PTE_VALID_BIT];
    pte_frame = word[PTE_FRAME_LSB +: FRW];
  end

endmodule

// File: rtl/segpage_walker.sv
module segpage_walker
  import segpage_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int SEGW = 4,
  parameter int IDXW = 16,
  parameter int OFFW = 12,
  parameter int LENW = 16,
  parameter int FRW  = 12,
  localparam int PAW = FRW + OFFW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [SEGW-1:0] seg,
  input  logic [IDXW-1:0] idx,
  input  logic [OFFW-1:0] off,
  input  logic [AW-1:0]   stbr,
  output logic            mem_rd_en,
  output logic [AW-1:0]   mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [AW-1:0]   seg_base,
  input  logic [LENW-1:0] seg_len,
  input  logic            pte_valid,
  input  logic [FRW-1:0]  pte_frame,
  output logic            busy,
  output logic            done,
  output logic [PAW-1:0]  paddr,
  output logic            fault,
  output logic [1:0]      fault_code
);

  walk_state_t     state_q;
  logic [IDXW-1:0] idx_q;
  logic [OFFW-1:0] off_q;
  logic            rd_en_q;
  logic [AW-1:0]   rd_addr_q;
  logic            done_q;
  logic            fault_q;
  logic [1:0]      fcode_q;
  logic [PAW-1:0]  paddr_q;
  logic            out_of_range;

  assign out_of_range = ({{(32-IDXW){1'b0}}, idx_q} >= {{(32-LENW){1'b0}}, seg_len});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      off_q     <= '0;
      rd_en_q   <= 1'b0;
      rd_addr_q <= '0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      fcode_q   <= FLT_NONE;
      paddr_q   <= '0;
    end else begin
      rd_en_q <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            idx_q     <= idx;
            off_q     <= off;
            rd_addr_q <= stbr + AW'(seg);
            rd_en_q   <= 1'b1;
            state_q   <= ST_SEG;
          end
        end
        ST_SEG: begin
          if (mem_rd_valid) begin
            if (out_of_range) begin
              fault_q <= 1'b1;
              fcode_q <= FLT_RANGE;
              state_q <= ST_FAULT;
            end else begin
              rd_addr_q <= seg_base + AW'(idx_q);
              rd_en_q   <= 1'b1;
              state_q   <= ST_PTE;
            end
          end
        end
        ST_PTE: begin
          if (mem_rd_valid) begin
            if (!pte_valid) begin
              fault_q <= 1'b1;
              fcode_q <= FLT_INVALID;
              state_q <= ST_FAULT;
            end else begin
              done_q  <= 1'b1;
              paddr_q <= {pte_frame, off_q};
              state_q <= ST_DONE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_en   = rd_en_q;
  assign mem_rd_addr = rd_addr_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign fault       = fault_q;
  assign fault_code  = fcode_q;
  assign paddr       = paddr_q;

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en); // R4
  AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy); // R4
  AST_NO_PTE_AFTER_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEG && mem_rd_valid && out_of_range) |=> (fault && !mem_rd_en)); // R6
  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && fault)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |=> (!done && !fault && !busy)); // R10
  AST_FAULT_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
    fault |-> (fault_code != FLT_NONE)); // R8

endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate #(
  parameter int LAW  = 32,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int SEGW = 4,
  parameter int OFFW = 12,
  parameter int LENW = 16,
  parameter int FRW  = 12,
  localparam int IDXW = LAW - SEGW - OFFW,
  localparam int PAW  = FRW + OFFW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [LAW-1:0] req_laddr,
  input  logic [AW-1:0]  seg_tbl_base,
  output logic           mem_rd_en,
  output logic [AW-1:0]  mem_rd_addr,
  input  logic           mem_rd_valid,
  input  logic [DW-1:0]  mem_rd_data,
  output logic           busy,
  output logic           done,
  output logic [PAW-1:0] paddr,
  output logic           fault,
  output logic [1:0]     fault_code
);

  logic [SEGW-1:0] seg;
  logic [IDXW-1:0] idx;
  logic [OFFW-1:0] off;
  logic [AW-1:0]   seg_base;
  logic [LENW-1:0] seg_len;
  logic            pte_valid;
  logic [FRW-1:0]  pte_frame;

  segpage_split #(.LAW(LAW), .SEGW(SEGW), .OFFW(OFFW)) u_split (
    .laddr (req_laddr),
    .seg   (seg),
    .idx   (idx),
    .off   (off)
  );

  segpage_entry_decode #(.DW(DW), .AW(AW), .LENW(LENW), .FRW(FRW)) u_dec (
    .word      (mem_rd_data),
    .seg_base  (seg_base),
    .seg_len   (seg_len),
    .pte_valid (pte_valid),
    .pte_frame (pte_frame)
  );

  segpage_walker #(
    .AW(AW), .DW(DW), .SEGW(SEGW), .IDXW(IDXW),
    .OFFW(OFFW), .LENW(LENW), .FRW(FRW)
  ) u_walk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .seg          (seg),
    .idx          (idx),
    .off          (off),
    .stbr         (seg_tbl_base),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .seg_base     (seg_base),
    .seg_len      (seg_len),
    .pte_valid    (pte_valid),
    .pte_frame    (pte_frame),
    .busy         (busy),
    .done         (done),
    .paddr        (paddr),
    .fault        (fault),
    .fault_code   (fault_code)
  );

endmodule

// File: tb/segpage_xlate_tb.sv
`timescale 1ns/1ps
module segpage_xlate_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_laddr = '0;
  logic [15:0] seg_tbl_base = 16'h0100;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic        busy, done, fault;
  logic [23:0] paddr;
  logic [1:0]  fault_code;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  segpage_xlate u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_laddr(req_laddr),
    .seg_tbl_base(seg_tbl_base), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .busy(busy),
    .done(done), .paddr(paddr), .fault(fault), .fault_code(fault_code)
  );

  // table memory model: response two cycles after the request
  logic [31:0] mem [0:1023];
  logic        v1;
  logic [15:0] a1;
  int          rd_cnt;
  logic [15:0] last_addr, prev_addr;

  always @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; mem_rd_valid <= 1'b0; mem_rd_data <= '0;
      rd_cnt <= 0; last_addr <= '0; prev_addr <= '0; a1 <= '0;
    end else begin
      v1 <= mem_rd_en;
      a1 <= mem_rd_addr;
      mem_rd_valid <= v1;
      mem_rd_data  <= mem[a1[9:0]];
      if (mem_rd_en) begin
        rd_cnt    <= rd_cnt + 1;
        prev_addr <= last_addr;
        last_addr <= mem_rd_addr;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  logic        r_done, r_fault;
  logic [1:0]  r_code;
  logic [23:0] r_paddr;
  int          r_reads;

  task automatic run_xlate(logic [31:0] la);
    int start;
    start = rd_cnt;
    r_done = 0; r_fault = 0; r_code = 0; r_paddr = 0;
    @(negedge clk);
    req_laddr = la; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done || fault) begin
        r_done = done; r_fault = fault; r_code = fault_code; r_paddr = paddr;
        break;
      end
      @(negedge clk);
    end
    r_reads = rd_cnt - start;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 done", {31'b0, done}, 0);
    check("R1 fault", {31'b0, fault}, 0);
    check("R1 rd_en", {31'b0, mem_rd_en}, 0);
  endtask

  task automatic t_normal;
    seg_tbl_base = 16'h0100;
    mem[10'h103] = {16'd8, 16'h0200};
    mem[10'h205] = 32'h0000_8ABC;
    run_xlate({4'd3, 16'd5, 12'h123});
    check("R5 done", {31'b0, r_done}, 1);
    check("R5 paddr", {8'b0, r_paddr}, 32'h00AB_C123);
    check("R4 two reads", r_reads, 2);
    check("R3 seg addr", {16'b0, prev_addr}, 32'h0103);
    check("R5 pte addr", {16'b0, last_addr}, 32'h0205);
  endtask

  task automatic t_boundary;
    mem[10'h207] = 32'h0000_8011;
    run_xlate({4'd3, 16'd7, 12'h0F0});
    check("R6 last ok", {31'b0, r_done}, 1);
    check("R6 last paddr", {8'b0, r_paddr}, 32'h0001_10F0);
    run_xlate({4'd3, 16'd8, 12'h000});
    check("R6 eq fault", {31'b0, r_fault}, 1);
    check("R6 code", {30'b0, r_code}, 1);
    check("R6 one read", r_reads, 1);
    run_xlate({4'd3, 16'hFFFF, 12'h000});
    check("R6 big idx", {31'b0, r_fault}, 1);
  endtask

  task automatic t_unused_seg;
    mem[10'h105] = 32'h0000_0300;
    run_xlate({4'd5, 16'd0, 12'h001});
    check("R7 fault", {31'b0, r_fault}, 1);
    check("R7 code", {30'b0, r_code}, 1);
    check("R7 no done", {31'b0, r_done}, 0);
  endtask

  task automatic t_invalid;
    mem[10'h202] = 32'h0000_0055;
    run_xlate({4'd3, 16'd2, 12'h777});
    check("R8 fault", {31'b0, r_fault}, 1);
    check("R8 code", {30'b0, r_code}, 2);
    check("R8 reads", r_reads, 2);
  endtask

  task automatic t_alt_base;
    seg_tbl_base = 16'h0300;
    mem[10'h300] = {16'h0100, 16'h0040};
    mem[10'h13F] = 32'h0000_8FFF;
    run_xlate({4'd0, 16'h00FF, 12'hFFF});
    check("R3 alt base paddr", {8'b0, r_paddr}, 32'h00FF_FFFF);
    check("R3 alt seg addr", {16'b0, prev_addr}, 32'h0300);
    check("R2 pte addr", {16'b0, last_addr}, 32'h013F);
    seg_tbl_base = 16'h0100;
  endtask

  task automatic t_busy_ignore;
    int start;
    bit seen_done;
    start = rd_cnt;
    seen_done = 0;
    @(negedge clk);
    req_laddr = {4'd3, 16'd5, 12'h456}; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 busy", {31'b0, busy}, 1);
    @(negedge clk);
    req_laddr = {4'd3, 16'd7, 12'h000}; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin
        seen_done = 1;
        check("R9 first paddr", {8'b0, paddr}, 32'h00AB_C456);
      end
      @(negedge clk);
    end
    check("R9 one done", {31'b0, seen_done}, 1);
    check("R9 reads", rd_cnt - start, 2);
    check("R10 idle", {31'b0, busy}, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_normal();
    t_boundary();
    t_unused_seg();
    t_invalid();
    t_alt_base();
    t_busy_ignore();
    run_xlate({4'd3, 16'd5, 12'h000});
    check("R10 back to back", {8'b0, r_paddr}, 32'h00AB_C000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule